// File: doc/BRIEF.md
# System Register Write Controller

This block holds a handful of processor control and status registers behind one write port and one read port. A write carries an index and a 32-bit word. For a storing register, the word is merged under a fixed per-register mask, so bits the architecture protects keep their value. For a group of command indices, nothing is stored. The write instead becomes a one-cycle invalidate request aimed at the instruction translation buffer, the data translation buffer, or both. The request uses a page number and an address-space identifier taken from fixed fields of the word.

A separate 8-bit port loads the condition-block state. Its bits are scattered into two fields of the status register. Reads are combinational from the stored state. Identification registers return build-time constants.

Top module: `sysreg_write_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release:
  - indices 0, 1 and 2 read 0;
  - index 3 reads 0x08000078;
  - all command outputs are 0.
- R2: Index map:
  - a write to index 0 (status) stores the whole word.
  - an `it_wr_en` write puts `it_wr_data[1:0]` into status bits 26:25 and `it_wr_data[7:2]` into status bits 15:10.
  - when both writes happen in the same cycle, the condition-state bits win in those two fields.
- R3: A write to index 1 (FP exception control) changes only bits 30:29. Every other bit keeps its value.
- R4: A write to index 2 (FP status/control) changes only the defined fields and keeps every other bit. The defined fields are:
  - the exception flags (bits 4:0 and 7);
  - length (18:16) and stride (21:20);
  - rounding mode (23:22);
  - flush-to-zero (24), default NaN (25) and alternative half precision (26);
  - saturation (27) and the N/Z/C/V flags (31:28).
  - The write mask is therefore 0xFFF7009F.
- R5: A write to index 3 (system control) stores every bit except bit 27, which keeps its old value.
- R6: Indices 4 to 8 are identification registers. Writes to them are ignored. They read, in index order, 0x00000F00, 0x10110222, 0x01111111, 0x80000003 and 0x00005A01.
- R7: Command outputs are registered:
  - a command write raises `tlb_valid` for exactly the next cycle;
  - with `tlb_valid` low, every command output is 0;
  - `tlb_target` bit 0 selects the instruction buffer and bit 1 the data buffer;
  - `tlb_kind` is 0 for all entries, 1 for page plus identifier, 2 for identifier only, and 3 for page in every identifier.
- R8: Indices 16 and 17 invalidate all entries in both buffers, index 18 only the instruction buffer, and index 19 only the data buffer. The page and identifier outputs are 0.
- R9: Indices 20 and 21 (both), 22 (instruction) and 23 (data) invalidate by page and identifier: page = data[31:12], identifier = data[7:0].
- R10: Indices 24 and 25 (both), 26 (instruction) and 27 (data) invalidate by identifier = data[7:0], with page 0.
- R11: Indices 28 and 29 invalidate by page = data[31:12] in both buffers, in every identifier. The identifier output is 0.
- R12: Command indices store nothing and read 0, as do all unmapped indices (9 to 15, 30, 31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Register index of the write |
| wr_data | input | 32 | Write word |
| it_wr_en | input | 1 | Condition-state write strobe |
| it_wr_data | input | 8 | Condition-state value |
| rd_idx | input | IDX_W | Read index |
| rd_data | output | 32 | Read value, combinational |
| tlb_valid | output | 1 | Invalidate request pulse |
| tlb_target | output | 2 | Bit 0 instruction buffer, bit 1 data buffer |
| tlb_kind | output | 2 | Invalidate kind code |
| tlb_page | output | 20 | Page number for address kinds |
| tlb_asid | output | 8 | Address-space identifier for identifier kinds |

## Verification
Every cycle, the assertions check the following:
- the protected bits of the FP exception, FP status and system control registers never move;
- the condition-state write lands in its two status fields;
- an idle command interface drives only zeros;
- a live request always names a target and zeroes the fields its kind does not use.

Only the bench scenarios can show that each command index picks the right target and kind, that identification registers stay constant under writes, and that the status write and the condition-state write merge correctly when they coincide. The bench does this by comparing reads and command outputs against its model on every clock.

// File: rtl/sysreg_write_ctrl.sv
module sysreg_write_ctrl #(
  parameter int          IDX_W     = 5,
  parameter logic [31:0] CTL_RESET = 32'h0800_0078,
  parameter logic [31:0] ID_TLBT   = 32'h0000_0F00,
  parameter logic [31:0] ID_FEAT0  = 32'h1011_0222,
  parameter logic [31:0] ID_FEAT1  = 32'h0111_1111,
  parameter logic [31:0] ID_MPID   = 32'h8000_0003,
  parameter logic [31:0] ID_FPID   = 32'h0000_5A01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             it_wr_en,
  input  logic [7:0]       it_wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_data,
  output logic             tlb_valid,
  output logic [1:0]       tlb_target,
  output logic [1:0]       tlb_kind,
  output logic [19:0]      tlb_page,
  output logic [7:0]       tlb_asid
);
  localparam logic [31:0] FPX_MASK  = 32'h6000_0000;
  localparam logic [31:0] FPSC_MASK = 32'hFFF7_009F;
  localparam logic [31:0] CTL_MASK  = ~(32'h1 << 27);
  localparam logic [1:0]  T_I = 2'b01, T_D = 2'b10, T_B = 2'b11;
  localparam logic [1:0]  K_ALL = 2'd0, K_VA = 2'd1, K_ASID = 2'd2, K_MVA = 2'd3;

  logic [31:0] status_q, fpx_q, fpsc_q, ctl_q;

  wire wr_st   = wr_en && (wr_idx == IDX_W'(0));
  wire wr_fpx  = wr_en && (wr_idx == IDX_W'(1));
  wire wr_fpsc = wr_en && (wr_idx == IDX_W'(2));
  wire wr_ctl  = wr_en && (wr_idx == IDX_W'(3));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      fpx_q    <= '0;
      fpsc_q   <= '0;
      ctl_q    <= CTL_RESET;
    end else begin
      if (wr_st) status_q <= wr_data;
      if (it_wr_en) begin
        status_q[26:25] <= it_wr_data[1:0];
        status_q[15:10] <= it_wr_data[7:2];
      end
      if (wr_fpx)  fpx_q  <= (wr_data & FPX_MASK)  | (fpx_q  & ~FPX_MASK);
      if (wr_fpsc) fpsc_q <= (wr_data & FPSC_MASK) | (fpsc_q & ~FPSC_MASK);
      if (wr_ctl)  ctl_q  <= (wr_data & CTL_MASK)  | (ctl_q  & ~CTL_MASK);
    end
  end

  logic       hit;
  logic [1:0] c_tgt, c_kind;

  always_comb begin
    hit    = 1'b1;
    c_tgt  = T_B;
    c_kind = K_ALL;
    case (wr_idx)
      IDX_W'(16), IDX_W'(17): ;
      IDX_W'(18): c_tgt = T_I;
      IDX_W'(19): c_tgt = T_D;
      IDX_W'(20), IDX_W'(21): c_kind = K_VA;
      IDX_W'(22): begin c_kind = K_VA; c_tgt = T_I; end
      IDX_W'(23): begin c_kind = K_VA; c_tgt = T_D; end
      IDX_W'(24), IDX_W'(25): c_kind = K_ASID;
      IDX_W'(26): begin c_kind = K_ASID; c_tgt = T_I; end
      IDX_W'(27): begin c_kind = K_ASID; c_tgt = T_D; end
      IDX_W'(28), IDX_W'(29): c_kind = K_MVA;
      default: hit = 1'b0;
    endcase
  end

  wire fire     = wr_en && hit;
  wire use_page = (c_kind == K_VA) || (c_kind == K_MVA);
  wire use_asid = (c_kind == K_VA) || (c_kind == K_ASID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tlb_valid  <= 1'b0;
      tlb_target <= '0;
      tlb_kind   <= '0;
      tlb_page   <= '0;
      tlb_asid   <= '0;
    end else begin
      tlb_valid  <= fire;
      tlb_target <= fire ? c_tgt : 2'b00;
      tlb_kind   <= fire ? c_kind : 2'b00;
      tlb_page   <= (fire && use_page) ? wr_data[31:12] : 20'h0;
      tlb_asid   <= (fire && use_asid) ? wr_data[7:0] : 8'h0;
    end
  end

  always_comb begin
    case (rd_idx)
      IDX_W'(0): rd_data = status_q;
      IDX_W'(1): rd_data = fpx_q;
      IDX_W'(2): rd_data = fpsc_q;
      IDX_W'(3): rd_data = ctl_q;
      IDX_W'(4): rd_data = ID_TLBT;
      IDX_W'(5): rd_data = ID_FEAT0;
      IDX_W'(6): rd_data = ID_FEAT1;
      IDX_W'(7): rd_data = ID_MPID;
      IDX_W'(8): rd_data = ID_FPID;
      default:   rd_data = 32'h0;
    endcase
  end
endmodule

// File: rtl/sysreg_write_ctrl_chk.sv
module sysreg_write_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        it_wr_en,
  input logic [7:0]  it_wr_data,
  input logic [31:0] status_q,
  input logic [31:0] fpx_q,
  input logic [31:0] fpsc_q,
  input logic [31:0] ctl_q,
  input logic        tlb_valid,
  input logic [1:0]  tlb_target,
  input logic [1:0]  tlb_kind,
  input logic [19:0] tlb_page,
  input logic [7:0]  tlb_asid
);
  localparam logic [31:0] FPX_HOLD  = 32'h9FFF_FFFF;
  localparam logic [31:0] FPSC_HOLD = 32'h0008_FF60;

  assert_it_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    it_wr_en |=> (status_q[26:25] == $past(it_wr_data[1:0])) &&
                 (status_q[15:10] == $past(it_wr_data[7:2])));

  assert_fpx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fpx_q & FPX_HOLD) == ($past(fpx_q) & FPX_HOLD));

  assert_fpsc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fpsc_q & FPSC_HOLD) == ($past(fpsc_q) & FPSC_HOLD));

  assert_ctl_nmfi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ctl_q[27]));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tlb_valid |-> (tlb_target == 2'b00 && tlb_kind == 2'd0 &&
                    tlb_page == 20'h0 && tlb_asid == 8'h0));

  assert_has_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_valid |-> tlb_target != 2'b00);

  assert_all_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_valid && tlb_kind == 2'd0) |-> (tlb_page == 20'h0 && tlb_asid == 8'h0));

  assert_asid_no_page_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_valid && tlb_kind == 2'd2) |-> tlb_page == 20'h0);

  assert_mva_no_asid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_valid && tlb_kind == 2'd3) |-> tlb_asid == 8'h0);
endmodule

bind sysreg_write_ctrl sysreg_write_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .it_wr_en(it_wr_en), .it_wr_data(it_wr_data),
  .status_q(status_q), .fpx_q(fpx_q), .fpsc_q(fpsc_q), .ctl_q(ctl_q),
  .tlb_valid(tlb_valid), .tlb_target(tlb_target), .tlb_kind(tlb_kind),
  .tlb_page(tlb_page), .tlb_asid(tlb_asid)
);

// File: tb/tb_sysreg_write_ctrl.sv
`timescale 1ns/1ps
module tb_sysreg_write_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        it_wr_en = 1'b0;
  logic [7:0]  it_wr_data = '0;
  logic [4:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        tlb_valid;
  logic [1:0]  tlb_target, tlb_kind;
  logic [19:0] tlb_page;
  logic [7:0]  tlb_asid;

  sysreg_write_ctrl dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit chk_on = 0, in_reset = 0, done = 0;

  logic [31:0] m_st, m_fpx, m_fpsc, m_ctl;
  logic        e_v;
  logic [1:0]  e_t, e_k;
  logic [19:0] e_p;
  logic [7:0]  e_a;

  task automatic cmd(input logic [1:0] t, input logic [1:0] k);
    e_v = 1'b1; e_t = t; e_k = k;
    e_p = (k == 2'd1 || k == 2'd3) ? wr_data[31:12] : 20'h0;
    e_a = (k == 2'd1 || k == 2'd2) ? wr_data[7:0] : 8'h0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_fpx = 0; m_fpsc = 0; m_ctl = 32'h0800_0078;
      e_v = 0; e_t = 0; e_k = 0; e_p = 0; e_a = 0;
    end else begin
      e_v = 0; e_t = 0; e_k = 0; e_p = 0; e_a = 0;
      if (wr_en) begin
        case (wr_idx)
          0: m_st = wr_data;
          1: begin m_fpx[30] = wr_data[30]; m_fpx[29] = wr_data[29]; end
          2: begin
               m_fpsc[4:0] = wr_data[4:0]; m_fpsc[7] = wr_data[7];
               m_fpsc[18:16] = wr_data[18:16]; m_fpsc[31:20] = wr_data[31:20];
             end
          3: begin
               m_ctl[26:0] = wr_data[26:0];
               m_ctl[31:28] = wr_data[31:28];
             end
          16, 17: cmd(2'b11, 2'd0);
          18: cmd(2'b01, 2'd0);
          19: cmd(2'b10, 2'd0);
          20, 21: cmd(2'b11, 2'd1);
          22: cmd(2'b01, 2'd1);
          23: cmd(2'b10, 2'd1);
          24, 25: cmd(2'b11, 2'd2);
          26: cmd(2'b01, 2'd2);
          27: cmd(2'b10, 2'd2);
          28, 29: cmd(2'b11, 2'd3);
          default: ;
        endcase
      end
      if (it_wr_en) begin
        m_st[26:25] = it_wr_data[1:0];
        m_st[15:10] = it_wr_data[7:2];
      end
    end
  end

  function automatic logic [31:0] exp_rd(input int idx);
    case (idx)
      0: return m_st;
      1: return m_fpx;
      2: return m_fpsc;
      3: return m_ctl;
      4: return 32'h0000_0F00;
      5: return 32'h1011_0222;
      6: return 32'h0111_1111;
      7: return 32'h8000_0003;
      8: return 32'h0000_5A01;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input int idx);
    if (in_reset) return "R1";
    case (idx)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5, 6, 7, 8: return "R6";
      default: return "R12";
    endcase
  endfunction

  function automatic string cmd_tag();
    if (in_reset) return "R1";
    if (!e_v) return "R7";
    case (e_k)
      2'd0: return "R8";
      2'd1: return "R9";
      2'd2: return "R10";
      default: return "R11";
    endcase
  endfunction

  always @(negedge clk) begin
    if (chk_on && !done) begin
      total++;
      if (rd_data !== exp_rd(int'(rd_idx))) begin
        bad++;
        $display("FAIL %s read idx %0d actual=%h expected=%h",
                 rd_tag(int'(rd_idx)), rd_idx, rd_data, exp_rd(int'(rd_idx)));
      end
      total++;
      if ({tlb_valid, tlb_target, tlb_kind, tlb_page, tlb_asid} !==
          {e_v, e_t, e_k, e_p, e_a}) begin
        bad++;
        $display("FAIL %s command actual=%h expected=%h", cmd_tag(),
                 {tlb_valid, tlb_target, tlb_kind, tlb_page, tlb_asid},
                 {e_v, e_t, e_k, e_p, e_a});
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d; rd_idx = 5'(idx);
    tick();
    wr_en = 1'b0;
    tick();
  endtask

  initial begin
    tick(); tick();
    chk_on = 1; in_reset = 1;
    for (int i = 0; i < 32; i++) begin rd_idx = 5'(i); tick(); end
    rst_n = 1'b1;
    tick();
    in_reset = 0;
    wr(1, 32'hFFFF_FFFF); wr(1, 32'h0000_0000); wr(1, 32'hDFFF_FFFF);
    wr(2, 32'hFFFF_FFFF); wr(2, 32'h0000_0000); wr(2, 32'h5A5A_A5A5);
    wr(3, 32'h0000_0000); wr(3, 32'hFFFF_FFFF); wr(3, 32'h1234_5678);
    wr(0, 32'hCAFE_F00D);
    it_wr_en = 1'b1; it_wr_data = 8'hB6; rd_idx = 0; tick(); it_wr_en = 1'b0; tick();
    wr_en = 1'b1; wr_idx = 0; wr_data = 32'hFFFF_FFFF;
    it_wr_en = 1'b1; it_wr_data = 8'h00; tick();
    wr_en = 1'b0; it_wr_en = 1'b0; tick();
    for (int i = 4; i < 16; i++) wr(i, 32'hFFFF_FFFF);
    for (int i = 16; i < 32; i++) wr(i, 32'hABCD_E5A7);
    wr_en = 1'b1; wr_idx = 20; wr_data = 32'h1111_2233; tick();
    wr_idx = 26; wr_data = 32'h4444_5566; tick();
    wr_idx = 29; wr_data = 32'h7777_8899; tick();
    wr_en = 1'b0; tick();
    for (int i = 0; i < 600; i++) begin
      wr_en = 1'($urandom);
      wr_idx = 5'($urandom);
      wr_data = $urandom;
      it_wr_en = (($urandom % 4) == 0);
      it_wr_data = 8'($urandom);
      rd_idx = 5'($urandom % 10);
      tick();
    end
    wr_en = 1'b0; it_wr_en = 1'b0;
    tick(); tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule